// File: doc/BRIEF.md
# Program/Erase Status Reporter

This block owns the byte returned to the host for every read access while a flash-style memory is busy with an internal program or erase. A command decoder elsewhere pulses a start input. With that pulse it supplies the operation kind, plus the address and value of the byte just loaded. From then on the block times the operation itself, in clock cycles. It replaces the array's read data with status bits until the time has run out.

Two status bits are produced. The polling bit (the most significant data bit) returns the inverse of that bit of the loaded byte when a program is running and the host reads the loaded address. During an erase it returns 0 at every address, because that is the inverse of the erased value. The toggle bit (the next bit down) alternates on each read access for the whole operation, whatever the address. The remaining bits pass the array data through. Once the timer expires, every bit carries the array data again. The host may begin polling at any cycle of the operation. The read strobe is one clock pulse per access. The interface logic raises it for an access opened by either the chip enable or the output enable, so toggling either one gives a new read.

Top module: `pe_status_reporter`

## Requirements
- R1: While reset is high and on the cycle after it, `rd_data_o` is 0. After reset no operation is running.
- R2: With no operation running, a read strobe sampled at a clock edge makes `rd_data_o` equal `array_data_i` from that edge on. Without a strobe, `rd_data_o` keeps its value.
- R3: A program is running and the host reads the latched program address. Bit DATA_W-1 of the result is the inverse of bit DATA_W-1 of the loaded byte.
- R4: A program is running and the host reads any other address. Bit DATA_W-1 is the array bit. Bits DATA_W-3 down to 0 are the array bits during any operation.
- R5: While an erase is running, bit DATA_W-1 of every read is 0.
- R6: During an operation, bit DATA_W-2 of a read alternates from one read to the next. Gaps between strobes do not change the alternation.
- R7: Each accepted start clears the toggle state. The first read of every operation returns 0 in bit DATA_W-2.
- R8: A program accepted at clock edge N gives status on reads sampled at edges N+1 through N+PROG_CYCLES. A read at edge N+PROG_CYCLES+1 returns the array data.
- R9: An erase accepted at edge N gives status on reads at edges N+1 through N+ERASE_CYCLES. A read at edge N+ERASE_CYCLES+1 returns the array data.
- R10: A start pulse that arrives while an operation is running is ignored. The kind, address, data and end time of the running operation stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_start_i | input | 1 | One-cycle pulse that launches an operation |
| op_erase_i | input | 1 | Kind of the launched operation: 1 erase, 0 program |
| op_addr_i | input | ADDR_W | Address of the loaded byte |
| op_data_i | input | DATA_W | Value of the loaded byte |
| rd_strobe_i | input | 1 | One-cycle pulse per host read access |
| rd_addr_i | input | ADDR_W | Address of the host read |
| array_data_i | input | DATA_W | True stored data at rd_addr_i |
| rd_data_o | output | DATA_W | Registered byte returned to the host |

## Verification
Some properties are checked on every clock cycle. After reset the output is cleared, and it holds between strobes. When the block is idle, a read returns the array data. During an erase, the polling bit reads 0. The toggle state is steady unless a busy read or a start is present. A start that arrives while busy leaves the latched byte alone. A checker counter also confirms that no operation lasts longer than its parameter allows. Only the bench scenarios can show the exact first and last busy edges of each operation kind, the alternation across reads spread out by gaps, the difference between reads at the loaded address and at other addresses, and the clean restart of the toggle for the next operation.

// File: rtl/pe_status_pkg.sv
package pe_status_pkg;

  typedef enum logic {
    OP_PROGRAM = 1'b0,
    OP_ERASE   = 1'b1
  } op_kind_e;

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/pe_busy_timer.sv
module pe_busy_timer
  import pe_status_pkg::*;
#(
  parameter int unsigned ADDR_W       = 16,
  parameter int unsigned DATA_W       = 8,
  parameter int unsigned PROG_CYCLES  = 20,
  parameter int unsigned ERASE_CYCLES = 60
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  op_kind_e          kind_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              accept_o,
  output logic              busy_o,
  output op_kind_e          kind_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_o
);

  localparam int unsigned MAX_CYC = max_u(PROG_CYCLES, ERASE_CYCLES);
  localparam int unsigned CNT_W   = (MAX_CYC < 2) ? 1 : $clog2(MAX_CYC);
  localparam logic [CNT_W-1:0] PROG_LOAD  = CNT_W'(PROG_CYCLES - 1);
  localparam logic [CNT_W-1:0] ERASE_LOAD = CNT_W'(ERASE_CYCLES - 1);

  logic             busy_q;
  logic [CNT_W-1:0] cnt_q;
  op_kind_e         kind_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;

  assign accept_o = start_i && !busy_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      kind_q <= OP_PROGRAM;
      addr_q <= '0;
      data_q <= '0;
    end else if (accept_o) begin
      busy_q <= 1'b1;
      cnt_q  <= (kind_i == OP_ERASE) ? ERASE_LOAD : PROG_LOAD;
      kind_q <= kind_i;
      addr_q <= addr_i;
      data_q <= data_i;
    end else if (busy_q) begin
      if (cnt_q == '0) begin
        busy_q <= 1'b0;
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  assign busy_o = busy_q;
  assign kind_o = kind_q;
  assign addr_o = addr_q;
  assign data_o = data_q;

endmodule

// File: rtl/pe_toggle_bit.sv
module pe_toggle_bit (
  input  logic clk,
  input  logic rst,
  input  logic clear_i,
  input  logic advance_i,
  output logic tog_o
);

  logic tog_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      tog_q <= 1'b0;
    end else if (clear_i) begin
      tog_q <= 1'b0;
    end else if (advance_i) begin
      tog_q <= ~tog_q;
    end
  end

  assign tog_o = tog_q;

endmodule

// File: rtl/pe_status_mux.sv
module pe_status_mux
  import pe_status_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              busy_i,
  input  op_kind_e          kind_i,
  input  logic [ADDR_W-1:0] lat_addr_i,
  input  logic [DATA_W-1:0] lat_data_i,
  input  logic              tog_i,
  input  logic              rd_strobe_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic [DATA_W-1:0] array_data_i,
  output logic [DATA_W-1:0] rd_data_o
);

  localparam int unsigned POLL_BIT = DATA_W - 1;
  localparam int unsigned TOG_BIT  = DATA_W - 2;

  logic [DATA_W-1:0] nxt;
  logic              addr_hit;
  logic              poll_val;

  assign addr_hit = (rd_addr_i == lat_addr_i);
  assign poll_val = (kind_i == OP_ERASE) ? 1'b0
                  : (addr_hit ? ~lat_data_i[POLL_BIT] : array_data_i[POLL_BIT]);

  for (genvar i = 0; i < DATA_W; i++) begin : g_lane
    if (i == POLL_BIT) begin : g_poll
      assign nxt[i] = busy_i ? poll_val : array_data_i[i];
    end else if (i == TOG_BIT) begin : g_tog
      assign nxt[i] = busy_i ? tog_i : array_data_i[i];
    end else begin : g_pass
      assign nxt[i] = array_data_i[i];
    end
  end

  logic [DATA_W-1:0] out_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_q <= '0;
    end else if (rd_strobe_i) begin
      out_q <= nxt;
    end
  end

  assign rd_data_o = out_q;

endmodule

// File: rtl/pe_status_reporter.sv
module pe_status_reporter
  import pe_status_pkg::*;
#(
  parameter int unsigned ADDR_W       = 16,
  parameter int unsigned DATA_W       = 8,
  parameter int unsigned PROG_CYCLES  = 20,
  parameter int unsigned ERASE_CYCLES = 60
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              op_start_i,
  input  logic              op_erase_i,
  input  logic [ADDR_W-1:0] op_addr_i,
  input  logic [DATA_W-1:0] op_data_i,
  input  logic              rd_strobe_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic [DATA_W-1:0] array_data_i,
  output logic [DATA_W-1:0] rd_data_o
);

  op_kind_e          req_kind;
  logic              accept_w;
  logic              busy_w;
  op_kind_e          kind_w;
  logic [ADDR_W-1:0] lat_addr_w;
  logic [DATA_W-1:0] lat_data_w;
  logic              tog_w;

  assign req_kind = op_erase_i ? OP_ERASE : OP_PROGRAM;

  pe_busy_timer #(
    .ADDR_W      (ADDR_W),
    .DATA_W      (DATA_W),
    .PROG_CYCLES (PROG_CYCLES),
    .ERASE_CYCLES(ERASE_CYCLES)
  ) u_timer (
    .clk     (clk),
    .rst     (rst),
    .start_i (op_start_i),
    .kind_i  (req_kind),
    .addr_i  (op_addr_i),
    .data_i  (op_data_i),
    .accept_o(accept_w),
    .busy_o  (busy_w),
    .kind_o  (kind_w),
    .addr_o  (lat_addr_w),
    .data_o  (lat_data_w)
  );

  pe_toggle_bit u_toggle (
    .clk      (clk),
    .rst      (rst),
    .clear_i  (accept_w),
    .advance_i(busy_w && rd_strobe_i),
    .tog_o    (tog_w)
  );

  pe_status_mux #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_mux (
    .clk         (clk),
    .rst         (rst),
    .busy_i      (busy_w),
    .kind_i      (kind_w),
    .lat_addr_i  (lat_addr_w),
    .lat_data_i  (lat_data_w),
    .tog_i       (tog_w),
    .rd_strobe_i (rd_strobe_i),
    .rd_addr_i   (rd_addr_i),
    .array_data_i(array_data_i),
    .rd_data_o   (rd_data_o)
  );

endmodule

// File: rtl/pe_status_checker.sv
module pe_status_checker
  import pe_status_pkg::*;
#(
  parameter int unsigned DATA_W       = 8,
  parameter int unsigned PROG_CYCLES  = 20,
  parameter int unsigned ERASE_CYCLES = 60
) (
  input logic              clk,
  input logic              rst,
  input logic              op_start_i,
  input logic              rd_strobe_i,
  input logic [DATA_W-1:0] array_data_i,
  input logic [DATA_W-1:0] rd_data_o,
  input logic              busy_w,
  input op_kind_e          kind_w,
  input logic [DATA_W-1:0] lat_data_w,
  input logic              tog_w
);

  localparam int unsigned LIMIT = max_u(PROG_CYCLES, ERASE_CYCLES);

  int unsigned busy_len;

  always_ff @(posedge clk) begin
    if (rst || !busy_w) busy_len <= 0;
    else                busy_len <= busy_len + 1;
  end

  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (rd_data_o == '0));

  a_r2_hold_without_strobe: assert property (@(posedge clk) disable iff (rst)
    !rd_strobe_i |=> $stable(rd_data_o));

  a_r2_idle_true_data: assert property (@(posedge clk) disable iff (rst)
    (!busy_w && rd_strobe_i) |=> (rd_data_o == $past(array_data_i)));

  a_r5_erase_poll_low: assert property (@(posedge clk) disable iff (rst)
    (busy_w && kind_w == OP_ERASE && rd_strobe_i) |=> (rd_data_o[DATA_W-1] == 1'b0));

  a_r6_toggle_reported: assert property (@(posedge clk) disable iff (rst)
    (busy_w && rd_strobe_i) |=> (rd_data_o[DATA_W-2] == $past(tog_w)));

  a_r7_toggle_steady: assert property (@(posedge clk) disable iff (rst)
    (!op_start_i && !(busy_w && rd_strobe_i)) |=> $stable(tog_w));

  a_r10_busy_start_ignored: assert property (@(posedge clk) disable iff (rst)
    (busy_w && op_start_i) |=> $stable(lat_data_w));

  a_r8_busy_bounded: assert property (@(posedge clk) disable iff (rst)
    busy_len <= LIMIT);

endmodule

bind pe_status_reporter pe_status_checker #(
  .DATA_W      (DATA_W),
  .PROG_CYCLES (PROG_CYCLES),
  .ERASE_CYCLES(ERASE_CYCLES)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .op_start_i  (op_start_i),
  .rd_strobe_i (rd_strobe_i),
  .array_data_i(array_data_i),
  .rd_data_o   (rd_data_o),
  .busy_w      (busy_w),
  .kind_w      (kind_w),
  .lat_data_w  (lat_data_w),
  .tog_w       (tog_w)
);

// File: tb/pe_status_reporter_tb.sv
`timescale 1ns/1ps
module pe_status_reporter_tb;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;
  localparam int DW = 8;
  localparam int PROG = 12;
  localparam int ERASE = 30;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          op_start_i = 1'b0;
  logic          op_erase_i = 1'b0;
  logic [AW-1:0] op_addr_i = '0;
  logic [DW-1:0] op_data_i = '0;
  logic          rd_strobe_i = 1'b0;
  logic [AW-1:0] rd_addr_i = '0;
  logic [DW-1:0] array_data_i = '0;
  logic [DW-1:0] rd_data_o;

  pe_status_reporter #(
    .ADDR_W(AW), .DATA_W(DW), .PROG_CYCLES(PROG), .ERASE_CYCLES(ERASE)
  ) u_dut (
    .clk(clk), .rst(rst), .op_start_i(op_start_i), .op_erase_i(op_erase_i),
    .op_addr_i(op_addr_i), .op_data_i(op_data_i), .rd_strobe_i(rd_strobe_i),
    .rd_addr_i(rd_addr_i), .array_data_i(array_data_i), .rd_data_o(rd_data_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    logic [DW-1:0] val;
    string         tag;
  } exp_t;
  exp_t sb[$];

  // reference state of the bench
  bit            m_valid = 1'b0;
  int            m_start = 0;
  int            m_len = 0;
  bit            m_erase = 1'b0;
  logic [AW-1:0] m_addr = '0;
  logic [DW-1:0] m_data = '0;
  bit            m_tog = 1'b0;

  function automatic bit m_busy(input int e);
    return m_valid && (e > m_start) && (e <= m_start + m_len);
  endfunction

  task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic rd_at(input int target, input logic [AW-1:0] a,
                       input logic [DW-1:0] arr, input string tag);
    exp_t it;
    int e;
    @(negedge clk);
    while (cyc + 1 < target) @(negedge clk);
    rd_strobe_i  = 1'b1;
    rd_addr_i    = a;
    array_data_i = arr;
    e = cyc + 1;
    it.val = arr;
    it.tag = tag;
    if (m_busy(e)) begin
      if (m_erase) it.val[DW-1] = 1'b0;
      else if (a == m_addr) it.val[DW-1] = ~m_data[DW-1];
      it.val[DW-2] = m_tog;
      m_tog = ~m_tog;
    end
    sb.push_back(it);
    @(posedge clk);
    #1 rd_strobe_i = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic [DW-1:0] arr, input string tag);
    rd_at(0, a, arr, tag);
  endtask

  task automatic start_op(input bit erase, input logic [AW-1:0] a, input logic [DW-1:0] d);
    int e;
    @(negedge clk);
    op_start_i = 1'b1;
    op_erase_i = erase;
    op_addr_i  = a;
    op_data_i  = d;
    e = cyc + 1;
    if (!m_busy(e)) begin
      m_valid = 1'b1;
      m_start = e;
      m_len   = erase ? ERASE : PROG;
      m_erase = erase;
      m_addr  = a;
      m_data  = d;
      m_tog   = 1'b0;
    end
    @(posedge clk);
    #1 op_start_i = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: pops one expected item per sampled strobe
  initial begin
    forever begin
      bit s;
      exp_t it;
      @(posedge clk);
      s = rd_strobe_i && !rst;
      @(negedge clk);
      if (s) begin
        if (sb.size() == 0) begin
          checks++; errors++;
          $display("FAIL scoreboard: actual=%02h expected=none", rd_data_o);
        end else begin
          it = sb.pop_front();
          check(it.tag, rd_data_o, it.val);
        end
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    int s0;
    logic [DW-1:0] held;
    repeat (3) @(negedge clk);
    check("R1 output during reset", rd_data_o, 8'h00);
    rst = 1'b0;
    @(negedge clk);
    check("R1 output after reset", rd_data_o, 8'h00);

    rd(16'h1234, 8'hA5, "R1 R2 idle read after reset");
    rd(16'h0001, 8'h3C, "R2 idle read second pattern");
    held = 8'h3C;
    array_data_i = 8'hFF;
    idle(3);
    check("R2 hold without strobe", rd_data_o, held);

    // program of 0x5A: polling bit reads 1
    start_op(1'b0, 16'h4000, 8'h5A);
    s0 = m_start;
    rd(16'h4000, 8'hFF, "R3 R6 R7 first program read");
    rd(16'h4000, 8'hFF, "R3 R6 second program read");
    rd(16'h0100, 8'h00, "R4 other address during program");
    rd(16'h0100, 8'h80, "R4 other address array bit high");
    idle(2);
    rd(16'h4000, 8'h15, "R6 read after gap");
    rd_at(s0 + PROG, 16'h4000, 8'h00, "R8 last busy edge of program");
    rd_at(s0 + PROG + 1, 16'h4000, 8'h00, "R8 first edge after program");
    rd(16'h4000, 8'h5A, "R8 true data after program");

    // program of 0xC3: polling bit reads 0
    start_op(1'b0, 16'h2AAA, 8'hC3);
    rd(16'h2AAA, 8'hFF, "R3 R7 fresh toggle polling low");
    rd(16'h2AAA, 8'hC3, "R3 R6 second read");
    rd(16'h2AAA, 8'hC3, "R6 third read");
    idle(PROG + 2);
    rd(16'h2AAA, 8'hC3, "R8 program over");

    // erase
    start_op(1'b1, 16'h0000, 8'h10);
    s0 = m_start;
    rd(16'h0000, 8'hFF, "R5 R7 erase read base");
    rd(16'hFFFF, 8'hFF, "R5 erase read top");
    start_op(1'b0, 16'h0050, 8'h01);
    rd(16'h0050, 8'hFF, "R10 start ignored during erase");
    rd(16'h0050, 8'h7E, "R10 R5 kind unchanged");
    rd_at(s0 + ERASE, 16'h1000, 8'hFF, "R9 R10 last busy edge of erase");
    rd_at(s0 + ERASE + 1, 16'h1000, 8'hFF, "R9 first edge after erase");

    // back-to-back operation restarts toggle
    start_op(1'b0, 16'h0007, 8'h00);
    rd(16'h0007, 8'h00, "R7 toggle restarts");
    rd(16'h0007, 8'h00, "R6 toggle alternates");

    idle(PROG + 4);
    check("R2 scoreboard drained", 8'(sb.size()), 8'h00);
    finish_run();
  end

endmodule